// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside a memory controller's ECC checker and keeps a software-visible record of corrected (single-bit) and uncorrectable (multi-bit) memory errors. The checker presents a one-cycle pulse for each error class, together with the physical address and the memory row of the failing access. The block keeps the first failing address, only to 4 KB page granularity, and keeps it until software acknowledges it. It also keeps, separately for each class, an occurred flag and the row of the first error of that class. No syndrome is kept.

Software reaches four 32-bit registers through a simple read/write port. The port stands in for configuration-space access. Reads are combinational and writes take effect on the clock edge. The registers are the error address pointer, the error status register, a command register that selects which error classes raise a system-error pulse, and an integrity mode register. The mode register turns logging off entirely when it is 00. The codes 01, 10 and 11 mean check only, correct, and correct with hardware scrub. In this block all three of them enable logging in the same way.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads 0 and `serr_o` is low.
- R2: Register index 0 (error address pointer) holds failing-address bits 31:12 in bits 31:12, a single-bit flag in bit 0 and a multi-bit flag in bit 1, and reads 0 in bits 11:2. When an error pulse arrives while both of its flags are clear and logging is on, the register captures the page of `fail_addr_i` and sets the flag of each class that pulsed.
- R3: While either flag in the address pointer is set, further error pulses change neither its page field nor its flags.
- R4: Writing register 0 clears each flag whose bit is written as 1, and leaves flags written as 0 untouched. The page field is never changed by a write.
- R5: Register index 1 (status) has a single-bit flag in bit 0 with its row in bits 3:1, and a multi-bit flag in bit 4 with its row in bits 7:5. A class's flag and row are captured from an error of that class only while that flag is clear, independently of the other class. The row stays after the flag is cleared.
- R6: Writing register 1 with bit 0 and/or bit 4 set to 1 clears the matching flag. Row fields and the other flag are unaffected.
- R7: Register index 2 (command) holds the single-bit enable in bit 0 and the multi-bit enable in bit 1. Register index 3 holds the 2-bit integrity mode in bits 1:0. Both are read/write, and their upper bits read 0.
- R8: With the integrity mode at 00, error pulses set no flag, capture nothing and raise no system error.
- R9: Single-bit and multi-bit pulses in the same cycle set both pointer flags with that cycle's page and set both status flags with that row.
- R10: `serr_o` is high for exactly the one cycle after an error is newly recorded in the status register for a class whose command enable is set. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sbe_i | input | 1 | Single-bit error pulse from the ECC checker |
| mbe_i | input | 1 | Multi-bit error pulse from the ECC checker |
| fail_addr_i | input | 32 | Physical address of the failing access |
| fail_row_i | input | 3 | Memory row of the failing access |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index (0 pointer, 1 status, 2 command, 3 mode) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| serr_o | output | 1 | One-cycle system-error pulse |

## Verification
The hardest condition to reach is a pointer register that is already holding a page while a different class then arrives, or a clear races with a fresh error. In that case the status register takes the new class while the address pointer must not. Directed sequences build this up on purpose: first one class is latched, then the other class is pulsed, then one flag at a time is cleared. Long random runs mix error pulses with writes of random masks to every register, including mode switches into and out of 00. Both-class pulses and clear-then-error cycles come up repeatedly.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int ROW_W    = 3;
  localparam int NCLS     = 2;   // class 0 single-bit, class 1 multi-bit
  localparam int RIDX_W   = 2;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int STRIDE   = ROW_W + 1;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_CHECK   = 2'b01,
    MODE_CORRECT = 2'b10,
    MODE_SCRUB   = 2'b11
  } integ_mode_e;

  localparam logic [RIDX_W-1:0] IDX_PTR  = 2'd0;
  localparam logic [RIDX_W-1:0] IDX_STAT = 2'd1;
  localparam logic [RIDX_W-1:0] IDX_CMD  = 2'd2;
  localparam logic [RIDX_W-1:0] IDX_MODE = 2'd3;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_LSB];
  endfunction

  function automatic logic [DATA_W-1:0] pack_ptr(input logic [PAGE_W-1:0] pg,
                                                 input logic [NCLS-1:0] fl);
    logic [DATA_W-1:0] v;
    v = '0;
    v[PAGE_LSB +: PAGE_W] = pg;
    v[NCLS-1:0] = fl;
    return v;
  endfunction
endpackage

// File: rtl/ecc_class_log.sv
module ecc_class_log
  import ecc_log_pkg::*;
#(
  parameter int RW = ROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          log_en,
  input  logic          evt,
  input  logic [RW-1:0] row_in,
  input  logic          clr,
  output logic          flag_o,
  output logic [RW-1:0] row_o,
  output logic          rec_o
);
  logic          flag_q;
  logic [RW-1:0] row_q;

  assign rec_o  = log_en & evt & ~flag_q;
  assign flag_o = flag_q;
  assign row_o  = row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else if (rec_o) begin
      flag_q <= 1'b1;
      row_q  <= row_in;
    end else if (clr) begin
      flag_q <= 1'b0;
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> (!flag_q || $stable(row_q))); // R5
  AST_REC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o |=> (flag_q && row_q == $past(row_in))); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!log_en && !flag_q) |=> !flag_q); // R8
  AST_REC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_o |=> !rec_o); // R10
endmodule

// File: rtl/ecc_addr_ptr.sv
module ecc_addr_ptr
  import ecc_log_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LSB = PAGE_LSB,
  parameter int NC = NCLS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_en,
  input  logic [NC-1:0]     evt,
  input  logic [AW-1:0]     addr_in,
  input  logic [NC-1:0]     clr,
  output logic [NC-1:0]     flags_o,
  output logic [AW-LSB-1:0] page_o,
  output logic              cap_o
);
  logic [NC-1:0]     flags_q;
  logic [AW-LSB-1:0] page_q;
  logic              unused_low;

  assign unused_low = ^addr_in[LSB-1:0];
  assign cap_o   = log_en & (|evt) & ~(|flags_q);
  assign flags_o = flags_q;
  assign page_o  = page_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      page_q  <= '0;
    end else if (cap_o) begin
      flags_q <= evt;
      page_q  <= addr_in[AW-1:LSB];
    end else begin
      flags_q <= flags_q & ~clr;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |=> $stable(page_q)); // R3
  AST_PTR_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags_q) |=> ((flags_q & ~$past(flags_q)) == '0)); // R3
  AST_PTR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> (flags_q == $past(evt))); // R2
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
  import ecc_log_pkg::*;
#(
  parameter int NC = NCLS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic          wr_mode,
  input  logic [NC-1:0] cmd_wdata,
  input  logic [1:0]    mode_wdata,
  output logic [NC-1:0] cmd_en_o,
  output integ_mode_e   mode_o
);
  logic [NC-1:0] cmd_q;
  integ_mode_e   mode_q;

  assign cmd_en_o = cmd_q;
  assign mode_o   = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mode_q <= MODE_OFF;
    end else begin
      if (wr_cmd)  cmd_q  <= cmd_wdata;
      if (wr_mode) mode_q <= integ_mode_e'(mode_wdata);
    end
  end

  AST_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(cmd_q)); // R7
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] fail_addr_i,
  input  logic [ROW_W-1:0]  fail_row_i,
  input  logic              reg_wr_i,
  input  logic [RIDX_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              serr_o
);
  logic [NCLS-1:0]   evt;
  logic [NCLS-1:0]   rec;
  logic [NCLS-1:0]   cls_flag;
  logic [ROW_W-1:0]  cls_row [NCLS];
  logic [NCLS-1:0]   ptr_flags;
  logic [PAGE_W-1:0] ptr_page;
  logic              ptr_cap;
  logic [NCLS-1:0]   cmd_en;
  integ_mode_e       mode;
  logic              log_en;
  logic              wr_ptr, wr_stat, wr_cmd, wr_mode;
  logic [DATA_W-1:0] stat_word;
  logic              serr_q;
  logic              unused_wdata;

  assign evt     = {mbe_i, sbe_i};
  assign log_en  = (mode != MODE_OFF);
  assign wr_ptr  = reg_wr_i && (reg_addr_i == IDX_PTR);
  assign wr_stat = reg_wr_i && (reg_addr_i == IDX_STAT);
  assign wr_cmd  = reg_wr_i && (reg_addr_i == IDX_CMD);
  assign wr_mode = reg_wr_i && (reg_addr_i == IDX_MODE);
  assign unused_wdata = ^reg_wdata_i;

  ecc_addr_ptr u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .log_en  (log_en),
    .evt     (evt),
    .addr_in (fail_addr_i),
    .clr     (wr_ptr ? reg_wdata_i[NCLS-1:0] : '0),
    .flags_o (ptr_flags),
    .page_o  (ptr_page),
    .cap_o   (ptr_cap)
  );

  for (genvar k = 0; k < NCLS; k++) begin : g_cls
    ecc_class_log u_cls (
      .clk    (clk),
      .rst_n  (rst_n),
      .log_en (log_en),
      .evt    (evt[k]),
      .row_in (fail_row_i),
      .clr    (wr_stat & reg_wdata_i[k*STRIDE]),
      .flag_o (cls_flag[k]),
      .row_o  (cls_row[k]),
      .rec_o  (rec[k])
    );
  end

  ecc_ctrl_regs u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .wr_mode    (wr_mode),
    .cmd_wdata  (reg_wdata_i[NCLS-1:0]),
    .mode_wdata (reg_wdata_i[1:0]),
    .cmd_en_o   (cmd_en),
    .mode_o     (mode)
  );

  always_comb begin
    stat_word = '0;
    for (int k = 0; k < NCLS; k++) begin
      stat_word[k*STRIDE]             = cls_flag[k];
      stat_word[k*STRIDE+1 +: ROW_W]  = cls_row[k];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      IDX_PTR:  reg_rdata_o = pack_ptr(ptr_page, ptr_flags);
      IDX_STAT: reg_rdata_o = stat_word;
      IDX_CMD:  reg_rdata_o[NCLS-1:0] = cmd_en;
      IDX_MODE: reg_rdata_o[1:0] = mode;
      default:  reg_rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= |(rec & cmd_en);
  end
  assign serr_o = serr_q;

  AST_SERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    serr_o |-> $past(|rec)); // R10
  AST_SERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en == '0) |=> !serr_o); // R10
  AST_BOTH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_cap && (&evt)) |=> (&ptr_flags)); // R9
  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !log_en |-> (!ptr_cap && rec == '0)); // R8
endmodule

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sbe, mbe;
  logic [31:0] faddr;
  logic [2:0]  frow;
  logic        wr;
  logic [1:0]  ridx;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        serr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [19:0] m_page;
  logic [1:0]  m_ef, m_sf, m_cmd, m_mode;
  logic [2:0]  m_row0, m_row1;
  logic        m_serr;

  always #5 clk = ~clk;

  ecc_err_log u0 (
    .clk(clk), .rst_n(rst_n), .sbe_i(sbe), .mbe_i(mbe),
    .fail_addr_i(faddr), .fail_row_i(frow),
    .reg_wr_i(wr), .reg_addr_i(ridx), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .serr_o(serr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_reg(input int idx);
    case (idx)
      0: return {m_page, 10'd0, m_ef};
      1: return {24'd0, m_row1, m_sf[1], m_row0, m_sf[0]};
      2: return {30'd0, m_cmd};
      default: return {30'd0, m_mode};
    endcase
  endfunction

  task automatic peek(input int idx, input string tag, input logic [31:0] exp);
    ridx = 2'(idx);
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic read_all();
    peek(0, "R2/R3/R4 pointer", exp_reg(0));
    peek(1, "R5/R6 status", exp_reg(1));
    peek(2, "R7 command", exp_reg(2));
    peek(3, "R7 mode", exp_reg(3));
  endtask

  task automatic step(input logic s, input logic m, input logic [31:0] a,
                      input logic [2:0] r, input logic w, input logic [1:0] wa,
                      input logic [31:0] wd);
    logic       ld;
    logic [1:0] ev, nw;
    @(negedge clk);
    wr = 1'b0;
    read_all();
    sbe = s; mbe = m; faddr = a; frow = r; wr = w; ridx = wa; wdata = wd;
    @(posedge clk);
    ld = (m_mode != 2'b00);
    ev = {m, s};
    nw = ev & {2{ld}} & ~m_sf;
    m_serr = |(nw & m_cmd);
    if (ld && (ev != 2'b00) && (m_ef == 2'b00)) begin
      m_ef = ev; m_page = a[31:12];
    end else if (w && wa == 2'd0) begin
      m_ef = m_ef & ~wd[1:0];
    end
    if (nw[0]) begin m_sf[0] = 1'b1; m_row0 = r; end
    else if (w && wa == 2'd1 && wd[0]) m_sf[0] = 1'b0;
    if (nw[1]) begin m_sf[1] = 1'b1; m_row1 = r; end
    else if (w && wa == 2'd1 && wd[4]) m_sf[1] = 1'b0;
    if (w && wa == 2'd2) m_cmd = wd[1:0];
    if (w && wa == 2'd3) m_mode = wd[1:0];
    #1;
    check("R10 serr", {31'd0, serr}, {31'd0, m_serr});
  endtask

  task automatic idle();
    step(0, 0, 32'h0, 3'd0, 0, 2'd0, 32'h0);
    wr = 1'b0;
  endtask

  task automatic settle_peek(input int idx, input string tag, input logic [31:0] exp);
    @(negedge clk);
    sbe = 0; mbe = 0; wr = 0;
    peek(idx, tag, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    m_page = '0; m_ef = '0; m_sf = '0; m_cmd = '0; m_mode = '0;
    m_row0 = '0; m_row1 = '0; m_serr = 0;
    rst_n = 0; sbe = 0; mbe = 0; faddr = '0; frow = '0; wr = 0; ridx = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 4; i++) peek(i, "R1 reset", 32'h0);
    check("R1 serr after reset", {31'd0, serr}, 32'h0);

    // R7 configuration
    step(0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFE);
    step(0, 0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
    settle_peek(3, "R7 mode upper zero", 32'h2);
    settle_peek(2, "R7 cmd upper zero", 32'h3);

    // R2 first single-bit error
    step(1, 0, 32'hABCD_E123, 3'd5, 0, 2'd0, 0);
    check("R10 pulse on single-bit", {31'd0, serr}, 32'h1);
    idle();
    check("R10 pulse lasts one cycle", {31'd0, serr}, 32'h0);
    settle_peek(0, "R2 pointer capture", 32'hABCD_E001);
    settle_peek(1, "R5 single-bit row", 32'h0000_000B);

    // R3 second class while pointer pending
    step(0, 1, 32'h5555_5FFF, 3'd2, 0, 2'd0, 0);
    idle();
    settle_peek(0, "R3 pointer held", 32'hABCD_E001);
    settle_peek(1, "R5 multi-bit independent", 32'h0000_005B);

    // R4 write-one-to-clear
    step(0, 0, 0, 0, 1, 2'd0, 32'h0);
    settle_peek(0, "R4 write zero keeps", 32'hABCD_E001);
    step(0, 0, 0, 0, 1, 2'd0, 32'hFFFF_F000);
    settle_peek(0, "R4 page not writable", 32'hABCD_E001);
    step(0, 0, 0, 0, 1, 2'd0, 32'h1);
    settle_peek(0, "R4 flag cleared page kept", 32'hABCD_E000);

    // R6 status clear of one class
    step(0, 0, 0, 0, 1, 2'd1, 32'h0000_0001);
    settle_peek(1, "R6 clear single-bit only", 32'h0000_005A);

    // R8 mode off
    step(0, 0, 0, 0, 1, 2'd3, 32'h0);
    step(1, 0, 32'h7777_7000, 3'd1, 0, 2'd0, 0);
    check("R8 no serr when off", {31'd0, serr}, 32'h0);
    settle_peek(0, "R8 pointer untouched", 32'hABCD_E000);
    settle_peek(1, "R8 status untouched", 32'h0000_005A);

    // R9 both classes same cycle
    step(0, 0, 0, 0, 1, 2'd3, 32'h3);
    step(0, 0, 0, 0, 1, 2'd1, 32'h0000_0011);
    step(1, 1, 32'h1234_5FFF, 3'd7, 0, 2'd0, 0);
    idle();
    settle_peek(0, "R9 both flags", 32'h1234_5003);
    settle_peek(1, "R9 both status", 32'h0000_00FF);

    // R10 masked enables
    step(0, 0, 0, 0, 1, 2'd2, 32'h0);
    step(0, 0, 0, 0, 1, 2'd1, 32'h11);
    step(1, 1, 32'h0000_1000, 3'd3, 0, 2'd0, 0);
    check("R10 no pulse when disabled", {31'd0, serr}, 32'h0);
    step(0, 0, 0, 0, 1, 2'd2, 32'h2);
    step(0, 0, 0, 0, 1, 2'd1, 32'h11);
    step(1, 1, 32'h0000_2000, 3'd4, 0, 2'd0, 0);
    check("R10 pulse via multi-bit enable", {31'd0, serr}, 32'h1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic       s, m, w;
      logic [1:0] wa;
      logic [31:0] wd;
      s  = ($urandom % 4) == 0;
      m  = ($urandom % 5) == 0;
      w  = ($urandom % 3) == 0;
      wa = 2'($urandom % 4);
      if (wa == 2'd3 && ($urandom % 4) != 0) wa = 2'd1;
      wd = (($urandom % 2) == 0) ? 32'($urandom % 32) : $urandom;
      step(s, m, $urandom, 3'($urandom % 8), w, wa, wd);
    end
    idle();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule